// File: doc/BRIEF.md
# Asynchronous Byte-Lane PSRAM Controller

This block connects a synchronous request port to an asynchronous pseudo-static RAM that holds 512K words of 16 bits. A client issues single-word reads or writes with a 19-bit word address, 16 bits of write data and one enable per byte lane. The controller then drives the memory's strobes: an active-low select, an active-high second select, an output enable, a write enable and two active-low lane enables. It also drives the outgoing half of the 16-bit data bus through a separate drive-enable and registers the incoming half. Each access ends with a one-cycle completion pulse on the response port.

All memory timing is counted in system clocks. The read window and the write pulse width are given in nanoseconds and converted to whole clock cycles, rounded up, from a clock-period parameter. The memory counts as selected only when the first select is low and the second is high. When no access is in progress, the controller deselects the memory, raises both lane enables and releases the data bus. A request that enables no lane completes in the next cycle and no strobe moves.

Top module: `psram_ctrl`

## Requirements
- R1: While the controller is idle (including right after reset), `mem_ce_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_lane_n`=2'b11, `mem_dq_oe`=0 and `req_ready`=1.
- R2: A lane enable in `mem_lane_n` is low only while the memory is selected (`mem_ce_n`=0 and `mem_ce2`=1), and the memory is selected exactly while an access with at least one enabled lane is in progress.
- R3: A read holds `mem_oe_n` low and `mem_we_n` high for RD_CYC = ceil(T_RD_NS / CLK_PERIOD_NS) consecutive cycles (9 at defaults). Address and lane enables stay stable for the whole window.
- R4: Read data is sampled from `mem_dq_i` at the end of the last read cycle. `rsp_rdata` bits 7:0 keep the sample only if `req_be[0]` was 1, and bits 15:8 keep it only if `req_be[1]` was 1. A lane that was not enabled reads as zero.
- R5: `mem_lane_n[0]` (data bits 7:0) is low during an access exactly when `req_be[0]` was 1. `mem_lane_n[1]` (data bits 15:8) is low exactly when `req_be[1]` was 1.
- R6: A write spends one setup cycle selected with `mem_we_n` high. It then holds `mem_we_n` low for WP_CYC = ceil(T_WP_NS / CLK_PERIOD_NS) cycles (7 at defaults), then spends one hold cycle with `mem_we_n` high. Address, `mem_dq_o` and lanes stay unchanged across all three phases.
- R7: `mem_dq_oe` is 1 only during the three write phases, and then `mem_oe_n` is 1.
- R8: `rsp_valid` is a single-cycle pulse in the cycle after the last cycle of each accepted request. For a write, `rsp_rdata` is zero.
- R9: A request with `req_be`=2'b00 raises `rsp_valid` in the very next cycle with `rsp_rdata`=0, and the memory stays deselected.
- R10: `req_ready` is 1 exactly when the controller is idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, including the cycle in which `rsp_valid` is shown.
- R11: `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, zero for disabled lanes and for writes |
| mem_addr | output | 19 | Memory address |
| mem_ce_n | output | 1 | First select, active low |
| mem_ce2 | output | 1 | Second select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 = lower byte |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from the memory |

## Verification
After a request is accepted on edge k, the strobes change at edge k. A read returns `rsp_valid` after edge k+RD_CYC, a write after edge k+WP_CYC+2, and a request with no enabled lane after edge k. The bench's reference model advances its own phase counter on the same edges. Every output is compared two nanoseconds after each rising edge, so the comparison always sees settled values. The memory model drives a filler byte on disabled lanes, which exposes any failure to mask them.

// File: rtl/psram_pkg.sv
package psram_pkg;

  typedef enum logic [2:0] {
    PS_IDLE  = 3'd0,
    PS_READ  = 3'd1,
    PS_WSET  = 3'd2,
    PS_WPUL  = 3'd3,
    PS_WHOLD = 3'd4
  } psram_phase_e;

  // whole clock cycles covering a time in ns, at least one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    if (c == 0) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
module psram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psram_cycle_timer.sv
module psram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/psram_lane_unit.sv
module psram_lane_unit #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              active,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] dq_in,
  output logic [LANES-1:0]  lane_n,
  output logic [DATA_W-1:0] dq_masked
);
  localparam int unsigned LW = DATA_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_n[g]               = ~(active & lane_en[g]);
    assign dq_masked[g*LW +: LW]   = lane_en[g] ? dq_in[g*LW +: LW] : '0;
  end
endmodule

// File: rtl/psram_seq.sv
module psram_seq
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2,
  parameter int unsigned RD_CYC = 9,
  parameter int unsigned WP_CYC = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output psram_phase_e      phase,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  input  logic [DATA_W-1:0] rd_masked
);
  localparam int unsigned MAXC  = (RD_CYC > WP_CYC) ? RD_CYC : WP_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD = CNT_W'(WP_CYC - 1);

  psram_phase_e      ph_q, ph_d;
  logic              accept, take_req;
  logic              t_load, t_done;
  logic [CNT_W-1:0]  t_val;
  logic              rsp_d, rsp_q;
  logic              cap_en, rdata_en;
  logic [DATA_W-1:0] rdata_d, rdata_q;

  psram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  assign req_ready = (ph_q == PS_IDLE);
  assign accept    = req_valid & req_ready;
  assign take_req  = accept & (|req_be);

  always_comb begin
    ph_d   = ph_q;
    t_load = 1'b0;
    t_val  = '0;
    rsp_d  = 1'b0;
    cap_en = 1'b0;
    unique case (ph_q)
      PS_IDLE: begin
        if (accept) begin
          if (req_be == '0) begin
            rsp_d = 1'b1;
          end else if (req_write) begin
            ph_d = PS_WSET;
          end else begin
            ph_d   = PS_READ;
            t_load = 1'b1;
            t_val  = RD_LOAD;
          end
        end
      end
      PS_READ: begin
        if (t_done) begin
          cap_en = 1'b1;
          rsp_d  = 1'b1;
          ph_d   = PS_IDLE;
        end
      end
      PS_WSET: begin
        ph_d   = PS_WPUL;
        t_load = 1'b1;
        t_val  = WP_LOAD;
      end
      PS_WPUL: begin
        if (t_done) ph_d = PS_WHOLD;
      end
      PS_WHOLD: begin
        rsp_d = 1'b1;
        ph_d  = PS_IDLE;
      end
      default: ph_d = PS_IDLE;
    endcase
  end

  assign rdata_en = rsp_d;
  assign rdata_d  = cap_en ? rd_masked : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PS_IDLE;
      rsp_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      rsp_q <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rdata_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (take_req) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  assign phase     = ph_q;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_RD_NS       = 70,
  parameter int unsigned T_WP_NS       = 55
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_ce2,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W/8-1:0] mem_lane_n,
  output logic [DATA_W-1:0]   mem_dq_o,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_i
);
  localparam int unsigned LANES  = DATA_W / 8;
  localparam int unsigned RD_CYC = ns_to_cyc(T_RD_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);

  logic              rst_i_n;
  psram_phase_e      phase;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] rd_masked;
  logic              busy, wr_phase;

  psram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  psram_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LANES  (LANES),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .phase     (phase),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .be_q      (be_q),
    .rd_masked (rd_masked)
  );

  assign busy     = (phase != PS_IDLE);
  assign wr_phase = (phase == PS_WSET) | (phase == PS_WPUL) | (phase == PS_WHOLD);

  psram_lane_unit #(.LANES(LANES), .DATA_W(DATA_W)) u_lanes (
    .active    (busy),
    .lane_en   (be_q),
    .dq_in     (mem_dq_i),
    .lane_n    (mem_lane_n),
    .dq_masked (rd_masked)
  );

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ~busy;
  assign mem_ce2   = busy;
  assign mem_oe_n  = ~(phase == PS_READ);
  assign mem_we_n  = ~(phase == PS_WPUL);
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = wr_phase;
endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [DATA_W/8-1:0] req_be,
  input logic                rsp_valid,
  input logic [ADDR_W-1:0]   mem_addr,
  input logic                mem_ce_n,
  input logic                mem_ce2,
  input logic                mem_oe_n,
  input logic                mem_we_n,
  input logic [DATA_W/8-1:0] mem_lane_n,
  input logic [DATA_W-1:0]   mem_dq_o,
  input logic                mem_dq_oe
);
  localparam int unsigned LANES = DATA_W / 8;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe));

  // R2
  lane_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lane_n != {LANES{1'b1}}) |-> (!mem_ce_n && mem_ce2));

  // R3
  read_window_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> ($stable(mem_addr) && $stable(mem_lane_n)));

  // R6
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $stable(mem_addr) && $stable(mem_dq_o)));

  // R6
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe));

  // R7
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce_n && mem_ce2));

  // R9
  empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_be == '0)) |=> (rsp_valid && mem_ce_n));

  // R11
  no_oe_we_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
endmodule

bind psram_ctrl psram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_be     (req_be),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_ce2    (mem_ce2),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_lane_n (mem_lane_n),
  .mem_dq_o   (mem_dq_o),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/psram_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_ctrl_tb_top;
  localparam int RD_N = (70 + 8 - 1) / 8;
  localparam int WP_N = (55 + 8 - 1) / 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_lane_n;
  logic [15:0] mem_dq_o, mem_dq_i;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  psram_ctrl dut_i (.*);

  // behavioural memory device
  logic [15:0] dev_mem [256];
  logic [15:0] ref_mem [256];

  always_comb begin
    if (!mem_ce_n && mem_ce2 && !mem_oe_n)
      mem_dq_i = {mem_lane_n[1] ? 8'hA5 : dev_mem[mem_addr[7:0]][15:8],
                  mem_lane_n[0] ? 8'hA5 : dev_mem[mem_addr[7:0]][7:0]};
    else
      mem_dq_i = 16'h5A5A;
  end

  always @(negedge clk) begin
    if (!mem_we_n && !mem_ce_n && mem_ce2) begin
      if (!mem_lane_n[0]) dev_mem[mem_addr[7:0]][7:0]  <= mem_dq_o[7:0];
      if (!mem_lane_n[1]) dev_mem[mem_addr[7:0]][15:8] <= mem_dq_o[15:8];
    end
  end

  // reference model: phase 0 idle, 1 read, 2 setup, 3 pulse, 4 hold
  int          m_ph, m_cnt;
  logic [18:0] m_addr;
  logic [15:0] m_wd, m_rd;
  logic [1:0]  m_be;
  logic        m_rsp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_rsp <= 1'b0; m_rd <= '0; m_cnt <= 0;
      m_addr <= '0; m_wd <= '0; m_be <= '0;
    end else begin
      m_rsp <= 1'b0;
      case (m_ph)
        0: if (req_valid) begin
             if (req_be == 2'b00) begin
               m_rsp <= 1'b1; m_rd <= '0;
             end else begin
               m_addr <= req_addr; m_wd <= req_wdata; m_be <= req_be;
               m_ph   <= req_write ? 2 : 1;
               m_cnt  <= RD_N - 1;
             end
           end
        1: if (m_cnt == 0) begin
             m_ph <= 0; m_rsp <= 1'b1;
             m_rd <= {m_be[1] ? ref_mem[m_addr[7:0]][15:8] : 8'h00,
                      m_be[0] ? ref_mem[m_addr[7:0]][7:0]  : 8'h00};
           end else m_cnt <= m_cnt - 1;
        2: begin m_ph <= 3; m_cnt <= WP_N - 1; end
        3: if (m_cnt == 0) m_ph <= 4; else m_cnt <= m_cnt - 1;
        default: begin
          m_ph <= 0; m_rsp <= 1'b1; m_rd <= '0;
          if (m_be[0]) ref_mem[m_addr[7:0]][7:0]  <= m_wd[7:0];
          if (m_be[1]) ref_mem[m_addr[7:0]][15:8] <= m_wd[15:8];
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk(req_ready == (m_ph == 0), "R10 req_ready", req_ready, m_ph == 0);
      chk(mem_ce_n == (m_ph == 0) && mem_ce2 == (m_ph != 0), "R2 select",
          {mem_ce_n, mem_ce2}, {m_ph == 0, m_ph != 0});
      chk(mem_oe_n == (m_ph != 1), "R3 oe_n", mem_oe_n, m_ph != 1);
      chk(mem_we_n == (m_ph != 3), "R6 we_n", mem_we_n, m_ph != 3);
      chk(mem_dq_oe == (m_ph >= 2), "R7 dq_oe", mem_dq_oe, m_ph >= 2);
      chk(mem_lane_n == ((m_ph == 0) ? 2'b11 : ~m_be), "R5 lanes", mem_lane_n,
          (m_ph == 0) ? 2'b11 : ~m_be);
      if (m_ph != 0) chk(mem_addr == m_addr, "R3 addr", mem_addr, m_addr);
      if (m_ph >= 2) chk(mem_dq_o == m_wd, "R6 dq_o", mem_dq_o, m_wd);
      chk(rsp_valid == m_rsp, "R8 rsp_valid", rsp_valid, m_rsp);
      if (m_rsp) chk(rsp_rdata == m_rd, "R4 rsp_rdata", rsp_rdata, m_rd);
      chk(mem_oe_n || mem_we_n, "R11 oe/we overlap", {mem_oe_n, mem_we_n}, 2'b11);
    end
  end

  task automatic do_req(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  logic [18:0] addrs [8];

  initial begin
    for (int i = 0; i < 256; i++) begin dev_mem[i] = '0; ref_mem[i] = '0; end
    addrs[0] = 19'h00000; addrs[1] = 19'h7FFFF; addrs[2] = 19'h12345;
    addrs[3] = 19'h0AA10; addrs[4] = 19'h55522; addrs[5] = 19'h3C033;
    addrs[6] = 19'h60044; addrs[7] = 19'h1F055;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe &&
        mem_lane_n == 2'b11 && req_ready, "R1 reset state",
        {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, mem_lane_n, req_ready},
        8'b10110111);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_ce_n && mem_lane_n == 2'b11 && !mem_dq_oe, "R1 idle after reset",
        {mem_ce_n, mem_lane_n, mem_dq_oe}, 4'b1110);

    // full-word writes at the address extremes
    for (int i = 0; i < 8; i++) do_req(1'b1, addrs[i], 16'h1111 * (i + 1) ^ 16'h0F0F, 2'b11);
    wait_idle();
    // single-lane writes
    do_req(1'b1, addrs[2], 16'hBEEF, 2'b01);
    do_req(1'b1, addrs[3], 16'hCAFE, 2'b10);
    // R9 empty request
    do_req(1'b0, addrs[4], 16'h0000, 2'b00);
    chk(rsp_valid && rsp_rdata == 16'h0 && mem_ce_n, "R9 empty read",
        {rsp_valid, mem_ce_n, rsp_rdata}, {2'b11, 16'h0});
    do_req(1'b1, addrs[4], 16'hFFFF, 2'b00);
    chk(rsp_valid && mem_ce_n && mem_we_n, "R9 empty write",
        {rsp_valid, mem_ce_n, mem_we_n}, 3'b111);
    do_req(1'b0, addrs[5], 16'h0, 2'b00);
    // reads with each lane pattern
    for (int i = 0; i < 8; i++) do_req(1'b0, addrs[i], 16'h0, 2'b11);
    do_req(1'b0, addrs[2], 16'h0, 2'b01);
    do_req(1'b0, addrs[3], 16'h0, 2'b10);
    // random mix
    for (int i = 0; i < 60; i++)
      do_req(1'($urandom_range(0, 1)), addrs[$urandom_range(0, 7)],
             16'($urandom), 2'($urandom_range(0, 3)));
    wait_idle();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL R10 watchdog expired actual=hung expected=idle");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule